// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This block sits between a CPU instruction/data fetch port and a slow on-chip code memory whose access time is fixed. Software programs a latency code into one memory-mapped control word. Every fetch accepted on the valid/ready port then holds the array address for exactly that many extra cycles before the read word is returned. Out of reset the latency is zero, so each fetch completes in one cycle.

The control word also carries enables for prefetch, the instruction cache and the data cache. These reach the outside as level outputs; the buffers they govern live elsewhere. Two further bits request a flush of either cache. A flush request is honoured only while the matching cache is disabled, and it leaves as a single-cycle strobe.

A latency change is picked up when the next fetch is accepted and never alters a fetch already in flight. Software confirms a change by reading the word back.

Top module: `flash_ws_top`

## Requirements
- R1: After reset the control word at offset 0 reads 0x0000_0000, all three enable outputs are low, no response is presented and `fetchReady` is high.
- R2: The latency field is control bits [2:0]; a code of n (0 to 7) makes a fetch accepted at a clock edge present `rspValid` in the cycle that begins n edges later, so each fetch occupies n+1 cycles.
- R3: While a fetch is waiting, `fetchReady` is low; in its final (response) cycle `fetchReady` is high, so a new fetch can be accepted on the same edge that ends the current one.
- R4: For the whole fetch `flashRd` is high and `flashAddr` holds the accepted address unchanged.
- R5: Writing a new latency while a fetch is waiting leaves that fetch's length unchanged; the next accepted fetch uses the new value.
- R6: Control bit 8 drives `prefetchEn`, bit 9 drives `icacheEn` and bit 10 drives `dcacheEn`; each reads back as written.
- R7: Writing 1 to bit 11 while `icacheEn` is 0 raises `icacheRst` for exactly the one cycle after the write edge; with `icacheEn` at 1 the write produces no strobe. Bit 11 always reads 0.
- R8: Writing 1 to bit 12 while `dcacheEn` is 0 raises `dcacheRst` for exactly the one cycle after the write edge; with `dcacheEn` at 1 the write produces no strobe. Bit 12 always reads 0.
- R9: Bits 7:3 and 31:13 read as zero even after ones are written to them.
- R10: Byte-enable lane 0 writes bits 7:0 and lane 1 writes bits 15:8; a lane whose enable is low leaves its bits unchanged. Writes take effect at the write edge with no wait.
- R11: Any `cfgAddr` other than 0 reads as zero, and writes to it change nothing.
- R12: `rspData` in the response cycle equals the array word at the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Control-port write strobe |
| cfgAddr | input | REG_ADDR_W | Control-port word offset |
| cfgByteEn | input | 4 | Write byte lanes |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for `cfgAddr` (combinational) |
| fetchValid | input | 1 | Fetch request valid |
| fetchAddr | input | ADDR_W | Fetch address |
| fetchReady | output | 1 | Fetch request can be accepted |
| rspValid | output | 1 | Response cycle |
| rspData | output | 32 | Fetched word, zero outside the response cycle |
| flashRd | output | 1 | Array read active |
| flashAddr | output | ADDR_W | Array address |
| flashRdData | input | 32 | Array output word |
| prefetchEn | output | 1 | Prefetch enable |
| icacheEn | output | 1 | Instruction cache enable |
| dcacheEn | output | 1 | Data cache enable |
| icacheRst | output | 1 | Instruction cache flush strobe |
| dcacheRst | output | 1 | Data cache flush strobe |

## Verification
The bench builds the block with the default three-bit latency field, which brings every code from zero to seven wait states into reach. It narrows the array address to 12 bits so that the array model can be a simple function of the address. It keeps a four-bit register offset, so that non-zero offsets can be probed for R11. With these values the bench can reach the longest wait, a latency rewrite in the middle of a fetch, and a back-to-back acceptance on the final cycle.

// File: rtl/flash_ws_pkg.sv
package flash_ws_pkg;

  localparam int CFG_W     = 32;
  localparam int PRFT_BIT  = 8;
  localparam int ICEN_BIT  = 9;
  localparam int DCEN_BIT  = 10;
  localparam int ICRST_BIT = 11;
  localparam int DCRST_BIT = 12;

  typedef struct packed {
    logic acceptRd;   // fetch accepted this edge
    logic countDown;  // decrement wait counter
    logic wrLane0;    // write bits 7:0
    logic wrLane1;    // write bits 15:8
    logic icRstOk;    // legal instruction-cache flush
    logic dcRstOk;    // legal data-cache flush
  } ws_strobe_t;

  typedef enum logic {ST_IDLE, ST_WAIT} ws_state_t;

endpackage

// File: rtl/flash_ws_ctrl.sv
module flash_ws_ctrl
  import flash_ws_pkg::*;
#(
  parameter int REG_ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetchValid,
  input  logic                  cntZero,
  input  logic                  cfgWrEn,
  input  logic [REG_ADDR_W-1:0] cfgAddr,
  input  logic [1:0]            cfgLaneEn,
  input  logic                  icRstReq,
  input  logic                  dcRstReq,
  input  logic                  icEnNow,
  input  logic                  dcEnNow,
  output ws_strobe_t            strb,
  output logic                  fetchReady,
  output logic                  rspValid,
  output logic                  busy
);

  ws_state_t state, stateNext;
  logic regSel;
  logic lastCyc;

  assign busy    = (state == ST_WAIT);
  assign regSel  = (cfgAddr == '0);
  assign lastCyc = busy && cntZero;

  always_comb begin
    fetchReady     = !busy || lastCyc;
    rspValid       = lastCyc;
    strb.acceptRd  = fetchValid && fetchReady;
    strb.countDown = busy && !cntZero;
    strb.wrLane0   = cfgWrEn && regSel && cfgLaneEn[0];
    strb.wrLane1   = cfgWrEn && regSel && cfgLaneEn[1];
    strb.icRstOk   = strb.wrLane1 && icRstReq && !icEnNow;
    strb.dcRstOk   = strb.wrLane1 && dcRstReq && !dcEnNow;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strb.acceptRd) stateNext = ST_WAIT;
      ST_WAIT: if (lastCyc && !strb.acceptRd) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

endmodule

// File: rtl/flash_ws_dp.sv
module flash_ws_dp
  import flash_ws_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LAT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ws_strobe_t        strb,
  input  logic [LAT_W-1:0]  wrLat,
  input  logic [2:0]        wrEnables,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [CFG_W-1:0]  flashRdData,
  input  logic              rspValid,
  output logic              cntZero,
  output logic              prefetchEn,
  output logic              icacheEn,
  output logic              dcacheEn,
  output logic              icacheRst,
  output logic              dcacheRst,
  output logic [CFG_W-1:0]  cfgImage,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [CFG_W-1:0]  rspData
);

  logic [LAT_W-1:0]  latReg;
  logic [LAT_W-1:0]  waitCnt;
  logic [ADDR_W-1:0] addrReg;

  // control word fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latReg     <= '0;
      prefetchEn <= 1'b0;
      icacheEn   <= 1'b0;
      dcacheEn   <= 1'b0;
      icacheRst  <= 1'b0;
      dcacheRst  <= 1'b0;
    end else begin
      if (strb.wrLane0) latReg <= wrLat;
      if (strb.wrLane1) {dcacheEn, icacheEn, prefetchEn} <= wrEnables;
      icacheRst <= strb.icRstOk;
      dcacheRst <= strb.dcRstOk;
    end
  end

  // wait-state counter, latency captured at acceptance only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waitCnt <= '0;
      addrReg <= '0;
    end else if (strb.acceptRd) begin
      waitCnt <= latReg;
      addrReg <= fetchAddr;
    end else if (strb.countDown) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign cntZero   = (waitCnt == '0);
  assign flashAddr = addrReg;
  assign rspData   = rspValid ? flashRdData : '0;

  always_comb begin
    cfgImage              = '0;
    cfgImage[LAT_W-1:0]   = latReg;
    cfgImage[PRFT_BIT]    = prefetchEn;
    cfgImage[ICEN_BIT]    = icacheEn;
    cfgImage[DCEN_BIT]    = dcacheEn;
  end

endmodule

// File: rtl/flash_ws_top.sv
module flash_ws_top
  import flash_ws_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int LAT_W      = 3,
  parameter int REG_ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgWrEn,
  input  logic [REG_ADDR_W-1:0] cfgAddr,
  input  logic [3:0]            cfgByteEn,
  input  logic [31:0]           cfgWrData,
  output logic [31:0]           cfgRdData,
  input  logic                  fetchValid,
  input  logic [ADDR_W-1:0]     fetchAddr,
  output logic                  fetchReady,
  output logic                  rspValid,
  output logic [31:0]           rspData,
  output logic                  flashRd,
  output logic [ADDR_W-1:0]     flashAddr,
  input  logic [31:0]           flashRdData,
  output logic                  prefetchEn,
  output logic                  icacheEn,
  output logic                  dcacheEn,
  output logic                  icacheRst,
  output logic                  dcacheRst
);

  ws_strobe_t       strb;
  logic             cntZero;
  logic [CFG_W-1:0] cfgImage;

  flash_ws_ctrl #(.REG_ADDR_W(REG_ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchValid (fetchValid),
    .cntZero    (cntZero),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgLaneEn  (cfgByteEn[1:0]),
    .icRstReq   (cfgWrData[ICRST_BIT]),
    .dcRstReq   (cfgWrData[DCRST_BIT]),
    .icEnNow    (icacheEn),
    .dcEnNow    (dcacheEn),
    .strb       (strb),
    .fetchReady (fetchReady),
    .rspValid   (rspValid),
    .busy       (flashRd)
  );

  flash_ws_dp #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .wrLat       (cfgWrData[LAT_W-1:0]),
    .wrEnables   (cfgWrData[DCEN_BIT:PRFT_BIT]),
    .fetchAddr   (fetchAddr),
    .flashRdData (flashRdData),
    .rspValid    (rspValid),
    .cntZero     (cntZero),
    .prefetchEn  (prefetchEn),
    .icacheEn    (icacheEn),
    .dcacheEn    (dcacheEn),
    .icacheRst   (icacheRst),
    .dcacheRst   (dcacheRst),
    .cfgImage    (cfgImage),
    .flashAddr   (flashAddr),
    .rspData     (rspData)
  );

  assign cfgRdData = (cfgAddr == '0) ? cfgImage : '0;

endmodule

// File: rtl/flash_ws_chk.sv
module flash_ws_chk #(
  parameter int ADDR_W     = 20,
  parameter int LAT_W      = 3,
  parameter int REG_ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fetchValid,
  input logic                  fetchReady,
  input logic                  rspValid,
  input logic                  flashRd,
  input logic [ADDR_W-1:0]     flashAddr,
  input logic [REG_ADDR_W-1:0] cfgAddr,
  input logic [31:0]           cfgRdData,
  input logic [31:0]           cfgImage,
  input logic                  icacheEn,
  input logic                  dcacheEn,
  input logic                  icacheRst,
  input logic                  dcacheRst
);

  logic [LAT_W-1:0] latSeen;
  logic [LAT_W:0]   cycSeen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latSeen <= '0;
      cycSeen <= '0;
    end else if (fetchValid && fetchReady) begin
      latSeen <= cfgImage[LAT_W-1:0];
      cycSeen <= '0;
    end else if (flashRd && !rspValid) begin
      cycSeen <= cycSeen + 1'b1;
    end
  end

  assert_read_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> (cycSeen == {1'b0, latSeen}));

  assert_ready_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flashRd && !rspValid) |-> !fetchReady);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flashRd && !rspValid) |=> (flashRd && $stable(flashAddr)));

  assert_icrst_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    icacheRst |-> !$past(icacheEn));

  assert_dcrst_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dcacheRst |-> !$past(dcacheEn));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgImage[31:11] == '0) && (cfgImage[7:LAT_W] == '0));

  assert_offset_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAddr != '0) |-> (cfgRdData == '0));

endmodule

bind flash_ws_top flash_ws_chk #(
  .ADDR_W(ADDR_W), .LAT_W(LAT_W), .REG_ADDR_W(REG_ADDR_W)
) u_chk (.*);

// File: tb/flash_ws_top_bench.sv
`timescale 1ns/1ps
module flash_ws_top_bench;

  localparam int ADDR_W = 12;
  localparam int LAT_W  = 3;
  localparam int RAW    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [RAW-1:0]    cfgAddr = '0;
  logic [3:0]        cfgByteEn = '0;
  logic [31:0]       cfgWrData = '0;
  logic [31:0]       cfgRdData;
  logic              fetchValid = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic              fetchReady, rspValid, flashRd;
  logic [31:0]       rspData, flashRdData;
  logic [ADDR_W-1:0] flashAddr;
  logic              prefetchEn, icacheEn, dcacheEn, icacheRst, dcacheRst;

  int checks = 0;
  int fails  = 0;
  logic icSeen, dcSeen;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] arrWord(input logic [ADDR_W-1:0] a);
    return {8'h5A, ~a[7:0], 4'h0, a};
  endfunction

  assign flashRdData = arrWord(flashAddr);

  flash_ws_top #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .REG_ADDR_W(RAW)) u_flash_ws_top (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .fetchReady(fetchReady),
    .rspValid(rspValid), .rspData(rspData), .flashRd(flashRd),
    .flashAddr(flashAddr), .flashRdData(flashRdData), .prefetchEn(prefetchEn),
    .icacheEn(icacheEn), .dcacheEn(dcacheEn), .icacheRst(icacheRst),
    .dcacheRst(dcacheRst)
  );

  // {latency code, fetch address}
  localparam logic [15:0] VEC [8] = '{
    16'h0_123, 16'h7_ABC, 16'h2_010, 16'h5_FFF,
    16'h1_000, 16'h6_555, 16'h3_0F0, 16'h4_AAA
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [RAW-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgByteEn = be; cfgWrData = d;
    @(negedge clk);
    icSeen = icacheRst; dcSeen = dcacheRst;
    cfgWrEn = 1'b0; cfgAddr = '0; cfgByteEn = '0; cfgWrData = '0;
  endtask

  task automatic cfgRead(input logic [RAW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
    cfgAddr = '0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, output int cyc, output logic [31:0] d,
                        output logic addrOk);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a;
    @(negedge clk);
    fetchValid = 1'b0;
    cyc = 1;
    addrOk = 1'b1;
    while (!rspValid && cyc < 40) begin
      if (!flashRd || flashAddr != a) addrOk = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (!flashRd || flashAddr != a) addrOk = 1'b0;
    d = rspData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, d;
    int cyc;
    logic aok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cfgRead('0, rd);
    chk(rd == 32'h0, "R1 reset word", rd, 32'h0);
    chk({prefetchEn, icacheEn, dcacheEn} == 3'b000, "R1 enables low",
        {29'h0, prefetchEn, icacheEn, dcacheEn}, 32'h0);
    chk(fetchReady && !rspValid, "R1 ready idle", {30'h0, fetchReady, rspValid}, 32'h2);
    doRead(12'h321, cyc, d, aok);
    chk(cyc == 1, "R1 zero wait after reset", cyc, 1);

    // R2 R4 R12: table of latency codes
    foreach (VEC[i]) begin
      logic [2:0] lat;
      logic [ADDR_W-1:0] a;
      lat = VEC[i][14:12];
      a   = VEC[i][11:0];
      cfgWrite('0, 4'b0001, {29'h0, lat});
      cfgRead('0, rd);
      chk(rd[2:0] == lat, "R2 latency readback", rd, {29'h0, lat});
      doRead(a, cyc, d, aok);
      chk(cyc == int'(lat) + 1, "R2 read length", cyc, int'(lat) + 1);
      chk(d == arrWord(a), "R12 read data", d, arrWord(a));
      chk(aok, "R4 address held", {31'h0, aok}, 32'h1);
    end

    // R3: ready low while waiting, high in final cycle, back-to-back accept
    cfgWrite('0, 4'b0001, 32'h2);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 12'h111;
    @(negedge clk);
    fetchValid = 1'b0;
    chk(!fetchReady, "R3 ready low while waiting", {31'h0, fetchReady}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    chk(rspValid && fetchReady, "R3 ready in response cycle", {30'h0, rspValid, fetchReady}, 32'h3);
    fetchValid = 1'b1; fetchAddr = 12'h222;
    @(negedge clk);
    fetchValid = 1'b0;
    cyc = 1;
    while (!rspValid && cyc < 40) begin @(negedge clk); cyc++; end
    chk(cyc == 3, "R3 back-to-back length", cyc, 3);
    chk(rspData == arrWord(12'h222), "R3 back-to-back data", rspData, arrWord(12'h222));

    // R5: latency rewrite during a waiting fetch
    cfgWrite('0, 4'b0001, 32'h5);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = 12'h0AB;
    @(negedge clk);
    fetchValid = 1'b0;
    cfgWrEn = 1'b1; cfgByteEn = 4'b0001; cfgWrData = 32'h1;
    cyc = 1;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = '0; cfgWrData = '0;
    cyc = 2;
    while (!rspValid && cyc < 40) begin @(negedge clk); cyc++; end
    chk(cyc == 6, "R5 in-flight length kept", cyc, 6);
    doRead(12'h0CD, cyc, d, aok);
    chk(cyc == 2, "R5 next fetch uses new latency", cyc, 2);

    // R6 R10: enables via lane 1, lane isolation
    cfgWrite('0, 4'b0010, 32'h0000_0700);
    cfgRead('0, rd);
    chk(rd == 32'h0000_0701, "R6 enables readback", rd, 32'h0000_0701);
    chk({prefetchEn, icacheEn, dcacheEn} == 3'b111, "R6 enable outputs",
        {29'h0, prefetchEn, icacheEn, dcacheEn}, 32'h7);
    cfgWrite('0, 4'b0001, 32'h0000_0006);
    cfgRead('0, rd);
    chk(rd == 32'h0000_0706, "R10 lane0 only", rd, 32'h0000_0706);
    cfgWrite('0, 4'b0010, 32'h0000_0105);
    cfgRead('0, rd);
    chk(rd == 32'h0000_0106, "R10 lane1 only", rd, 32'h0000_0106);

    // R7 R8: flush blocked while enabled
    cfgWrite('0, 4'b0010, 32'h0000_0600);
    cfgWrite('0, 4'b0010, 32'h0000_1E00);
    chk(!icSeen && !dcSeen, "R7 R8 flush blocked when enabled", {30'h0, icSeen, dcSeen}, 32'h0);
    // disable, then flush instruction cache
    cfgWrite('0, 4'b0010, 32'h0000_0000);
    cfgWrite('0, 4'b0010, 32'h0000_0800);
    chk(icSeen && !dcSeen, "R7 icache flush strobe", {30'h0, icSeen, dcSeen}, 32'h2);
    @(negedge clk);
    chk(!icacheRst, "R7 strobe one cycle", {31'h0, icacheRst}, 32'h0);
    cfgRead('0, rd);
    chk(rd[11] == 1'b0, "R7 bit reads zero", rd, {rd[31:12], 1'b0, rd[10:0]});
    cfgWrite('0, 4'b0010, 32'h0000_1000);
    chk(dcSeen && !icSeen, "R8 dcache flush strobe", {30'h0, icSeen, dcSeen}, 32'h1);
    @(negedge clk);
    chk(!dcacheRst, "R8 strobe one cycle", {31'h0, dcacheRst}, 32'h0);
    cfgRead('0, rd);
    chk(rd[12] == 1'b0, "R8 bit reads zero", rd, {rd[31:13], 1'b0, rd[11:0]});

    // R9: reserved bits
    cfgWrite('0, 4'b1111, 32'hFFFF_FFFF);
    cfgRead('0, rd);
    chk(rd == 32'h0000_0707, "R9 reserved zero", rd, 32'h0000_0707);

    // R11: other offsets
    cfgWrite(4'h1, 4'b1111, 32'h0000_0000);
    cfgRead('0, rd);
    chk(rd == 32'h0000_0707, "R11 write elsewhere ignored", rd, 32'h0000_0707);
    cfgRead(4'h1, rd);
    chk(rd == 32'h0, "R11 other offset reads zero", rd, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule